// File: doc/BRIEF.md
# Tester Channel Waveform Formatter

This block turns one per-cycle pattern bit into the drive waveform of a single tester channel. Every tester cycle is divided into sub-cycle ticks. Two programmable edges sit inside that cycle. The delay edge starts the active part of the cycle. The width edge ends it. Each edge is given as a one-hot coarse word and a one-hot fine word. The coarse word counts half periods and carries a separate even/odd select. The fine word counts ticks inside a half period and also holds two force bits.

A format code chooses how the pattern bit and the two edges combine. The five formats are non-return-to-zero, return-to-zero, return-to-one, return-complement and return-to-tristate. A byte-wide register file programs the block, and each channel owns a 24-byte window in that file. Timing and format writes go to a staging copy, which is moved to the working copy at the next cycle boundary.

Force-bit combinations can hold the pin at a fixed level. They can also disable one edge so that the other edge is seen on its own. An I/O control register drives two level-select outputs. The same register returns a captured phase-comparison bit when read.

Top module: `tcw_formatter`

## Requirements
- R1: After reset, drv_out is 0, drv_en is 1, the format is NRZ, and every register of the channel reads 0.
- R2: cyc_mark pulses for one clock at tick 0 of every tester cycle, and a cycle is CYC_TICKS = 2*(COARSE_W-2)*(FINE_W-2) = 400 clocks long.
- R3: The byte address is CHAN_ID*24 + chain*8 + reg, with chain 0 = delay edge, 1 = width edge and 2 = control. Within a timing chain, reg 0 and reg 1 hold coarse[7:0] and coarse[15:8], and reg 2, 3 and 4 hold fine[7:0], fine[15:8] and fine[23:16]. Control reg 5 holds the format and control reg 6 is the I/O control register. Writes outside the channel's window change nothing, and reads outside it return 0.
- R4: The coarse word marks a half-period position p with the lowest set bit among bits 0..9. Bit 11 (with bit 10 clear) selects an odd half count, and bit 10 selects an even one. The half count is 2p+odd.
- R5: The fine word marks a fine step s with the lowest set bit among bits 0..19. The edge tick is (2p+odd)*20 + s. An all-zero field counts as position 0.
- R6: Format code 0 (NRZ) drives the previous cycle's bit before the delay edge and the current bit from the delay edge to the end of the cycle. Codes 5..7 also act as NRZ.
- R7: Format code 1 (RZ) drives the current bit from the delay edge up to the width edge and drives 0 at all other times.
- R8: Format code 2 (RO) drives the current bit between the delay and width edges and drives 1 at all other times.
- R9: Format code 3 (RC) drives the complement of the bit outside the pulse. Format code 4 (RT) keeps drv_en high only inside the pulse and drives drv_out 0 while drv_en is low. Both use the same edge timing as RZ.
- R10: A width edge at or before the delay edge is ignored, so the pulse then runs from the delay edge to the end of the cycle.
- R11: Fine bit 21 (force high) on the delay chain together with fine bit 20 (force low) on the width chain holds drv_out at 1. Fine bit 20 on the delay chain together with bit 21 on the width chain holds drv_out at 0. Both holds ignore the data and keep drv_en at 1.
- R12: Outside those pairs, any force bit on the delay chain puts the delay edge at tick 0, and any force bit on the width chain removes the width edge.
- R13: Timing and format writes take effect at tick 0 of the next cycle and never in the middle of the current cycle. The pattern bit is captured at the end of each cycle for use in the next one.
- R14: I/O control bit 1 drives io_ttl_en and bit 2 drives io_asamp_en, one clock after the write. Bit 0 reads back the drv_out level captured at the last ref_strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_bit | input | 1 | Pattern bit for the next tester cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Combinational read data |
| ref_strobe | input | 1 | Captures drv_out into the phase bit |
| drv_out | output | 1 | Drive level |
| drv_en | output | 1 | Drive enable; low means tristate |
| cyc_mark | output | 1 | Tick-0 marker aligned with drv_out |
| io_ttl_en | output | 1 | Level-select control |
| io_asamp_en | output | 1 | Analog-sample control |

## Verification
The value of drv_out for tick t appears one clock after the internal counter holds t. cyc_mark has the same latency, so the bench counts its sampling instants from the falling edge at which it sees cyc_mark, and that instant is tick 0. A register write or pattern bit given during cycle n first shows at tick 0 of cycle n+1. Each vector is therefore programmed two cycles before the cycle that is compared tick by tick. The I/O control outputs are checked one clock after their write, and read data is sampled after the address settles.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
  typedef enum logic [2:0] {
    FMT_NRZ = 3'd0,
    FMT_RZ  = 3'd1,
    FMT_RO  = 3'd2,
    FMT_RC  = 3'd3,
    FMT_RT  = 3'd4
  } fmt_e;

  localparam int CHAIN_SPAN = 8;
  localparam int CH_SPAN    = 3 * CHAIN_SPAN;
  localparam int C_DLY = 0;
  localparam int C_WID = 1;
  localparam int C_CTL = 2;
  localparam int R_CLO = 0;
  localparam int R_CHI = 1;
  localparam int R_F0  = 2;
  localparam int R_F1  = 3;
  localparam int R_F2  = 4;
  localparam int R_FMT = 5;
  localparam int R_IO  = 6;

  function automatic fmt_e to_fmt(input logic [2:0] raw);
    case (raw)
      3'd1:    return FMT_RZ;
      3'd2:    return FMT_RO;
      3'd3:    return FMT_RC;
      3'd4:    return FMT_RT;
      default: return FMT_NRZ;
    endcase
  endfunction
endpackage

// File: rtl/tcw_regfile.sv
module tcw_regfile
  import tcw_pkg::*;
#(
  parameter int CHAN_ID  = 0,
  parameter int AW       = 10,
  parameter int DW       = 8,
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  input  logic                ph_bit,
  input  logic                cyc_end,
  output logic [COARSE_W-1:0] coarse_o [2],
  output logic [FINE_W-1:0]   fine_o [2],
  output fmt_e                fmt_o,
  output logic                ttl_en,
  output logic                asamp_en
);
  localparam int BASE    = CHAN_ID * CH_SPAN;
  localparam int OW      = $clog2(CH_SPAN);
  localparam int IO_IDX  = C_CTL * CHAIN_SPAN + R_IO;
  localparam int FMT_IDX = C_CTL * CHAIN_SPAN + R_FMT;

  logic [DW-1:0] stg_q [CH_SPAN];
  logic [DW-1:0] stg_d [CH_SPAN];
  logic [COARSE_W-1:0] s_coarse [2];
  logic [FINE_W-1:0]   s_fine [2];
  logic [COARSE_W-1:0] a_coarse_q [2];
  logic [FINE_W-1:0]   a_fine_q [2];
  logic [2:0]          a_fmt_q;

  logic [AW-1:0] woff, roff;
  logic          whit, rhit;

  assign woff = wr_addr - AW'(BASE);
  assign roff = rd_addr - AW'(BASE);
  assign whit = (wr_addr >= AW'(BASE)) && (woff < AW'(CH_SPAN));
  assign rhit = (rd_addr >= AW'(BASE)) && (roff < AW'(CH_SPAN));

  // staging copy: next-state
  always_comb begin
    for (int i = 0; i < CH_SPAN; i++) stg_d[i] = stg_q[i];
    if (wr_en && whit) stg_d[woff[OW-1:0]] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CH_SPAN; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < CH_SPAN; i++) stg_q[i] <= stg_d[i];
    end
  end

  // per-chain views of the staged bytes
  for (genvar g = 0; g < 2; g++) begin : g_chain
    assign s_coarse[g] = COARSE_W'({stg_q[g*CHAIN_SPAN+R_CHI], stg_q[g*CHAIN_SPAN+R_CLO]});
    assign s_fine[g]   = FINE_W'({stg_q[g*CHAIN_SPAN+R_F2], stg_q[g*CHAIN_SPAN+R_F1],
                                  stg_q[g*CHAIN_SPAN+R_F0]});

    // working copy, loaded only at the cycle boundary
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_coarse_q[g] <= '0;
        a_fine_q[g]   <= '0;
      end else if (cyc_end) begin
        a_coarse_q[g] <= s_coarse[g];
        a_fine_q[g]   <= s_fine[g];
      end
    end

    assign coarse_o[g] = a_coarse_q[g];
    assign fine_o[g]   = a_fine_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       a_fmt_q <= '0;
    else if (cyc_end) a_fmt_q <= stg_q[FMT_IDX][2:0];
  end

  assign fmt_o    = to_fmt(a_fmt_q);
  assign ttl_en   = stg_q[IO_IDX][1];
  assign asamp_en = stg_q[IO_IDX][2];

  always_comb begin
    rd_data = '0;
    if (rhit) begin
      if (roff[OW-1:0] == OW'(IO_IDX)) rd_data = {stg_q[IO_IDX][DW-1:1], ph_bit};
      else                             rd_data = stg_q[roff[OW-1:0]];
    end
  end
endmodule

// File: rtl/tcw_edge_decode.sv
module tcw_edge_decode #(
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 22,
  parameter int TW       = 9
) (
  input  logic [COARSE_W-1:0] coarse,
  input  logic [FINE_W-1:0]   fine,
  output logic [TW-1:0]       edge_tick,
  output logic                frc_hi,
  output logic                frc_lo
);
  localparam int POS_N = COARSE_W - 2;
  localparam int STG_N = FINE_W - 2;

  logic odd_sel;
  int unsigned pos, stp;

  assign odd_sel = coarse[COARSE_W-1] & ~coarse[COARSE_W-2];
  assign frc_lo  = fine[FINE_W-2];
  assign frc_hi  = fine[FINE_W-1];

  // lowest set bit wins in both one-hot fields
  always_comb begin
    pos = 0;
    for (int i = POS_N - 1; i >= 0; i--) if (coarse[i]) pos = i;
  end

  always_comb begin
    stp = 0;
    for (int i = STG_N - 1; i >= 0; i--) if (fine[i]) stp = i;
  end

  assign edge_tick = TW'((2 * pos + (odd_sel ? 1 : 0)) * STG_N + stp);
endmodule

// File: rtl/tcw_shaper.sv
module tcw_shaper
  import tcw_pkg::*;
#(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tick,
  input  logic [TW-1:0] t_dly,
  input  logic [TW-1:0] t_wid,
  input  logic          dly_fh,
  input  logic          dly_fl,
  input  logic          wid_fh,
  input  logic          wid_fl,
  input  fmt_e          fmt,
  input  logic          bit_cur,
  input  logic          bit_prev,
  output logic          drv_out,
  output logic          drv_en
);
  logic d_frc, w_frc, d_lvl, w_lvl, pulse;
  logic [TW-1:0] eff_dly;
  logic out_d, en_d;

  assign d_frc   = dly_fh | dly_fl;
  assign w_frc   = wid_fh | wid_fl;
  assign eff_dly = d_frc ? '0 : t_dly;
  assign d_lvl   = d_frc || (tick >= t_dly);
  assign w_lvl   = !w_frc && (t_wid > eff_dly) && (tick >= t_wid);
  assign pulse   = d_lvl & ~w_lvl;

  always_comb begin
    en_d  = 1'b1;
    out_d = 1'b0;
    if (dly_fh && wid_fl) begin
      out_d = 1'b1;
    end else if (dly_fl && wid_fh) begin
      out_d = 1'b0;
    end else begin
      case (fmt)
        FMT_RZ:  out_d = pulse & bit_cur;
        FMT_RO:  out_d = pulse ? bit_cur : 1'b1;
        FMT_RC:  out_d = pulse ? bit_cur : ~bit_cur;
        FMT_RT:  begin
          en_d  = pulse;
          out_d = pulse & bit_cur;
        end
        default: out_d = d_lvl ? bit_cur : bit_prev;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_out <= 1'b0;
      drv_en  <= 1'b1;
    end else begin
      drv_out <= out_d;
      drv_en  <= en_d;
    end
  end
endmodule

// File: rtl/tcw_formatter.sv
module tcw_formatter
  import tcw_pkg::*;
#(
  parameter int CHAN_ID  = 0,
  parameter int AW       = 10,
  parameter int DW       = 8,
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pat_bit,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          ref_strobe,
  output logic          drv_out,
  output logic          drv_en,
  output logic          cyc_mark,
  output logic          io_ttl_en,
  output logic          io_asamp_en
);
  localparam int STG_N     = FINE_W - 2;
  localparam int POS_N     = COARSE_W - 2;
  localparam int CYC_TICKS = 2 * POS_N * STG_N;
  localparam int TW        = $clog2(CYC_TICKS);

  logic [1:0]    rsync_q;
  logic          rst_n_s;
  logic [TW-1:0] tick_q, tick_d;
  logic          cyc_end;
  logic          cur_q, cur_d, prev_q, prev_d, ph_q, ph_d, mark_d;

  logic [COARSE_W-1:0] coarse [2];
  logic [FINE_W-1:0]   fine [2];
  logic [TW-1:0]       etick [2];
  logic [1:0]          fh, fl;
  fmt_e                act_fmt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  assign cyc_end = (tick_q == TW'(CYC_TICKS - 1));

  always_comb begin
    tick_d = cyc_end ? '0 : tick_q + 1'b1;
    cur_d  = cyc_end ? pat_bit : cur_q;
    prev_d = cyc_end ? cur_q : prev_q;
    ph_d   = ref_strobe ? drv_out : ph_q;
    mark_d = (tick_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      tick_q   <= '0;
      cur_q    <= 1'b0;
      prev_q   <= 1'b0;
      ph_q     <= 1'b0;
      cyc_mark <= 1'b0;
    end else begin
      tick_q   <= tick_d;
      cur_q    <= cur_d;
      prev_q   <= prev_d;
      ph_q     <= ph_d;
      cyc_mark <= mark_d;
    end
  end

  tcw_regfile #(
    .CHAN_ID(CHAN_ID), .AW(AW), .DW(DW), .COARSE_W(COARSE_W), .FINE_W(FINE_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ph_bit(ph_q), .cyc_end(cyc_end),
    .coarse_o(coarse), .fine_o(fine), .fmt_o(act_fmt),
    .ttl_en(io_ttl_en), .asamp_en(io_asamp_en)
  );

  for (genvar g = 0; g < 2; g++) begin : g_edge
    tcw_edge_decode #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .TW(TW)) dec_i (
      .coarse(coarse[g]), .fine(fine[g]), .edge_tick(etick[g]),
      .frc_hi(fh[g]), .frc_lo(fl[g])
    );
  end

  tcw_shaper #(.TW(TW)) shape_i (
    .clk(clk), .rst_n(rst_n_s), .tick(tick_q),
    .t_dly(etick[C_DLY]), .t_wid(etick[C_WID]),
    .dly_fh(fh[C_DLY]), .dly_fl(fl[C_DLY]), .wid_fh(fh[C_WID]), .wid_fl(fl[C_WID]),
    .fmt(act_fmt), .bit_cur(cur_q), .bit_prev(prev_q),
    .drv_out(drv_out), .drv_en(drv_en)
  );
endmodule

// File: rtl/tcw_formatter_chk.sv
module tcw_formatter_chk #(
  parameter int CYC_TICKS = 400
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_mark,
  input logic       drv_out,
  input logic       drv_en,
  input logic [2:0] fmt_act,
  input logic       dly_fh,
  input logic       dly_fl,
  input logic       wid_fh,
  input logic       wid_fl
);
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (cyc_mark) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  p_cycle_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_mark && seen_q) |-> (gap_q == 16'(CYC_TICKS - 1)));

  p_mark_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_mark |=> !cyc_mark);

  p_hold_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_fh && wid_fl) |=> (drv_out && drv_en));

  p_hold_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_fl && wid_fh && !(dly_fh && wid_fl)) |=> (!drv_out && drv_en));

  p_tristate_fmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> ($past(fmt_act) == 3'd4));

  p_tristate_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> !drv_out);
endmodule

bind tcw_formatter tcw_formatter_chk #(.CYC_TICKS(CYC_TICKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_mark(cyc_mark), .drv_out(drv_out), .drv_en(drv_en),
  .fmt_act(act_fmt), .dly_fh(fh[0]), .dly_fl(fl[0]), .wid_fh(fh[1]), .wid_fl(fl[1])
);

// File: tb/tcw_formatter_tb_top.sv
module tcw_formatter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH   = 2;
  localparam int BASE = CH * 24;
  localparam int STG  = 20;
  localparam int CYC  = 400;

  typedef struct packed {
    logic [2:0] fmt;
    logic [3:0] dp;
    logic       dodd;
    logic [4:0] df;
    logic       dfh;
    logic       dfl;
    logic [3:0] wp;
    logic       wodd;
    logic [4:0] wf;
    logic       wfh;
    logic       wfl;
    logic       dat;
    logic       prv;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 4'd2, 1'b0, 5'd5,  1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd6},  // R6 R4 R5
    '{3'd0, 4'd3, 1'b1, 5'd0,  1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd6},  // R6 odd half
    '{3'd1, 4'd1, 1'b0, 5'd3,  1'b0, 1'b0, 4'd5, 1'b1, 5'd7, 1'b0, 1'b0, 1'b1, 1'b0, 8'd7},  // R7
    '{3'd1, 4'd1, 1'b0, 5'd3,  1'b0, 1'b0, 4'd5, 1'b1, 5'd7, 1'b0, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 zero bit
    '{3'd2, 4'd0, 1'b1, 5'd2,  1'b0, 1'b0, 4'd4, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd8},  // R8
    '{3'd3, 4'd1, 1'b0, 5'd3,  1'b0, 1'b0, 4'd5, 1'b1, 5'd7, 1'b0, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 RC
    '{3'd4, 4'd1, 1'b0, 5'd3,  1'b0, 1'b0, 4'd5, 1'b1, 5'd7, 1'b0, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 RT
    '{3'd4, 4'd1, 1'b0, 5'd3,  1'b0, 1'b0, 4'd5, 1'b1, 5'd7, 1'b0, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 RT zero
    '{3'd1, 4'd2, 1'b0, 5'd5,  1'b0, 1'b0, 4'd2, 1'b0, 5'd5, 1'b0, 1'b0, 1'b1, 1'b0, 8'd10}, // R10 equal
    '{3'd1, 4'd5, 1'b0, 5'd0,  1'b0, 1'b0, 4'd1, 1'b0, 5'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'd10}, // R10 before
    '{3'd1, 4'd0, 1'b0, 5'd0,  1'b1, 1'b0, 4'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd11}, // R11 high
    '{3'd2, 4'd0, 1'b0, 5'd0,  1'b0, 1'b1, 4'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd11}, // R11 low
    '{3'd1, 4'd0, 1'b0, 5'd0,  1'b0, 1'b1, 4'd3, 1'b0, 5'd4, 1'b0, 1'b0, 1'b1, 1'b0, 8'd12}, // R12 width only
    '{3'd1, 4'd2, 1'b1, 5'd9,  1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd12}, // R12 delay only
    '{3'd0, 4'd9, 1'b1, 5'd19, 1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4}   // R4 last tick
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pat_bit, wr_en, ref_strobe;
  logic [9:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       drv_out, drv_en, cyc_mark, io_ttl_en, io_asamp_en;

  int n_chk = 0;
  int n_err = 0;
  int tpos  = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tcw_formatter #(.CHAN_ID(CH)) dut_i (
    .clk(clk), .rst_n(rst_n), .pat_bit(pat_bit), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ref_strobe(ref_strobe),
    .drv_out(drv_out), .drv_en(drv_en), .cyc_mark(cyc_mark),
    .io_ttl_en(io_ttl_en), .io_asamp_en(io_asamp_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    tpos++;
  endtask

  task automatic wait_mark();
    do @(negedge clk); while (!cyc_mark);
    tpos = 0;
  endtask

  task automatic adv_to(input int t);
    while (tpos < t) step();
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = 10'(a);
    wr_data = 8'(d);
    step();
    wr_en   = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 10'(a);
    #1;
    d = int'(rd_data);
  endtask

  function automatic int coarse_w(input int p, input bit odd);
    return (1 << p) | (odd ? (1 << 11) : (1 << 10));
  endfunction

  function automatic int fine_w(input int s, input bit fh, input bit fl);
    return (1 << s) | (fl ? (1 << 20) : 0) | (fh ? (1 << 21) : 0);
  endfunction

  task automatic prog(input vec_t v);
    int dc, dfn, wc, wfn;
    dc  = coarse_w(v.dp, v.dodd);
    dfn = fine_w(v.df, v.dfh, v.dfl);
    wc  = coarse_w(v.wp, v.wodd);
    wfn = fine_w(v.wf, v.wfh, v.wfl);
    wr(BASE + 0, dc & 255);
    wr(BASE + 1, dc >> 8);
    wr(BASE + 2, dfn & 255);
    wr(BASE + 3, (dfn >> 8) & 255);
    wr(BASE + 4, dfn >> 16);
    wr(BASE + 8, wc & 255);
    wr(BASE + 9, wc >> 8);
    wr(BASE + 10, wfn & 255);
    wr(BASE + 11, (wfn >> 8) & 255);
    wr(BASE + 12, wfn >> 16);
    wr(BASE + 21, int'(v.fmt));
  endtask

  // expected {drv_en, drv_out} at tick t, from R4..R12
  function automatic logic [1:0] expv(input vec_t v, input int t);
    int  td, tw, ed;
    bit  dfrc, wfrc, d, w, p;
    td   = (2 * int'(v.dp) + int'(v.dodd)) * STG + int'(v.df);
    tw   = (2 * int'(v.wp) + int'(v.wodd)) * STG + int'(v.wf);
    dfrc = v.dfh | v.dfl;
    wfrc = v.wfh | v.wfl;
    ed   = dfrc ? 0 : td;
    d    = dfrc || (t >= td);
    w    = !wfrc && (tw > ed) && (t >= tw);
    p    = d && !w;
    if (v.dfh && v.wfl) return 2'b11;
    if (v.dfl && v.wfh) return 2'b10;
    case (v.fmt)
      3'd1:    return {1'b1, p & v.dat};
      3'd2:    return {1'b1, p ? v.dat : 1'b1};
      3'd3:    return {1'b1, p ? v.dat : ~v.dat};
      3'd4:    return {p, p & v.dat};
      default: return {1'b1, d ? v.dat : v.prv};
    endcase
  endfunction

  task automatic check_cycle(input vec_t v, input int idx);
    int bad = 0;
    int ft = 0;
    int fa = 0;
    int fe = 0;
    for (int t = 0; t < CYC; t++) begin
      logic [1:0] e;
      e = expv(v, t);
      if ({drv_en, drv_out} !== e) begin
        if (bad == 0) begin
          ft = t;
          fa = int'({drv_en, drv_out});
          fe = int'(e);
        end
        bad++;
      end
      if (t < CYC - 1) step();
    end
    chk(bad == 0, $sformatf("R%0d", v.req), fa, fe,
        $sformatf("vector %0d {en,out} first bad tick %0d", idx, ft));
  endtask

  initial begin
    int d;
    int n;
    rst_n = 1'b0;
    pat_bit = 1'b0;
    wr_en = 1'b0;
    ref_strobe = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(drv_out == 1'b0, "R1", int'(drv_out), 0, "drv_out after reset");
    chk(drv_en == 1'b1, "R1", int'(drv_en), 1, "drv_en after reset");
    rd(BASE + 21, d);
    chk(d == 0, "R1", d, 0, "format register after reset");
    rd(BASE + 0, d);
    chk(d == 0, "R1", d, 0, "delay coarse after reset");

    // R2 cycle length
    wait_mark();
    n = 0;
    do begin step(); n++; end while (!cyc_mark);
    tpos = 0;
    chk(n == CYC, "R2", n, CYC, "clocks between cycle marks");

    // R3 address window
    wr(BASE + 13, 8'h5A);
    rd(BASE + 13, d);
    chk(d == 8'h5A, "R3", d, 8'h5A, "own register readback");
    wr((CH + 1) * 24 + 13, 8'hA5);
    rd(BASE + 13, d);
    chk(d == 8'h5A, "R3", d, 8'h5A, "foreign write left own register");
    rd((CH + 1) * 24 + 13, d);
    chk(d == 0, "R3", d, 0, "read outside window");
    wr(BASE + 13, 0);

    // vector table: program, set bits, compare a whole cycle
    for (int i = 0; i < NV; i++) begin
      wait_mark();
      prog(VEC[i]);
      pat_bit = VEC[i].prv;
      wait_mark();
      pat_bit = VEC[i].dat;
      wait_mark();
      check_cycle(VEC[i], i);
    end
    rd(BASE + 21, d);
    chk(d == 0, "R3", d, 0, "format byte at offset 21 holds last code");

    // R13 write lands at next cycle only: RZ, delay at tick 0, width at 200
    wait_mark();
    prog('{3'd1, 4'd0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd5, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd13});
    pat_bit = 1'b1;
    wait_mark();
    wait_mark();
    wr(BASE + 8, 8'h04);  // width coarse p=2 odd -> tick 100
    wr(BASE + 9, 8'h08);
    // R14 phase capture while the pin is high
    adv_to(20);
    ref_strobe = 1'b1;
    step();
    ref_strobe = 1'b0;
    rd(BASE + 22, d);
    chk((d & 1) == 1, "R14", d & 1, 1, "phase bit captured high");
    adv_to(150);
    chk(drv_out == 1'b1, "R13", int'(drv_out), 1, "old width kept in current cycle");
    wait_mark();
    adv_to(150);
    chk(drv_out == 1'b0, "R13", int'(drv_out), 0, "new width applied next cycle");
    ref_strobe = 1'b1;
    step();
    ref_strobe = 1'b0;
    rd(BASE + 22, d);
    chk((d & 1) == 0, "R14", d & 1, 0, "phase bit captured low");

    // R14 I/O control outputs
    wr(BASE + 22, 8'h06);
    chk(io_ttl_en == 1'b1, "R14", int'(io_ttl_en), 1, "ttl enable set");
    chk(io_asamp_en == 1'b1, "R14", int'(io_asamp_en), 1, "analog sample enable set");
    rd(BASE + 22, d);
    chk(d == 8'h06, "R14", d, 8'h06, "io control readback");
    wr(BASE + 22, 8'h02);
    chk(io_asamp_en == 1'b0, "R14", int'(io_asamp_en), 0, "analog sample enable cleared");
    chk(io_ttl_en == 1'b1, "R14", int'(io_ttl_en), 1, "ttl enable kept");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule